// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a load or store and the value the base register should take afterwards. It is given the base register contents and an offset. The offset is either a 12-bit unsigned immediate or a register value that has been passed through a barrel shift by a constant amount. A direction bit picks whether the offset is added to the base or subtracted from it.

An indexing bit selects pre-indexed or post-indexed operation. In pre-indexed operation the transfer uses the adjusted address. The base is rewritten only when the writeback bit asks for it. In post-indexed operation the transfer uses the base unchanged, and the adjusted value always goes back to the base register.

The arithmetic is combinational. A registered stage captures each request and presents the results one clock later. Those results then stay on the outputs until the next request arrives.

Top module: `ldst_agu`

## Requirements
- R1: When `off_is_imm`=1 the offset is `imm_off` zero-extended to 32 bits, and `reg_off`, `sh_kind` and `sh_amt` have no effect.
- R2: When `off_is_imm`=0 and `sh_kind`=2'b00, the offset is `reg_off` shifted left by `sh_amt`, with zeros filling in from the bottom. A shift amount of 0 leaves the value unchanged, and the same holds for every shift kind.
- R3: `sh_kind`=2'b01 shifts `reg_off` right by `sh_amt`, with zeros filling in from the top.
- R4: `sh_kind`=2'b10 shifts `reg_off` right by `sh_amt`, and every vacated top bit is a copy of bit 31.
- R5: `sh_kind`=2'b11 rotates `reg_off` right by `sh_amt`. Bits that leave at the bottom re-enter at the top.
- R6: `up`=1 gives base + offset and `up`=0 gives base − offset. Both are computed modulo 2^32, and there is no overflow indication.
- R7: When `pre`=1, both `xfer_addr` and `new_base` equal the adjusted value, and `base_we` equals `wb_req`.
- R8: When `pre`=0, `xfer_addr` equals the unmodified base, `new_base` equals the adjusted value, and `base_we` is 1 whatever `wb_req` is.
- R9: `rsp_valid` is high in the cycle after a cycle in which `req_valid` is high, and low in the cycle after a cycle in which `req_valid` is low.
- R10: While `req_valid` is low, `xfer_addr`, `new_base` and `base_we` keep the values of the last request.
- R11: While `rst_n` is low and right after it is released, `rsp_valid`, `xfer_addr`, `new_base` and `base_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| base_in | input | 32 | Base register value |
| off_is_imm | input | 1 | 1: offset is the immediate; 0: offset is the shifted register |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset value before the shift |
| sh_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| sh_amt | input | 5 | Constant shift amount, 0 to 31 |
| up | input | 1 | 1: add the offset; 0: subtract it |
| pre | input | 1 | 1: pre-indexed; 0: post-indexed |
| wb_req | input | 1 | Writeback request, used only when pre-indexed |
| rsp_valid | output | 1 | Results of the previous cycle's request are on the outputs |
| xfer_addr | output | 32 | Address for the memory transfer |
| new_base | output | 32 | Value to be written to the base register |
| base_we | output | 1 | Base register write enable |

## Verification
Any corruption in the shift stage or the adder shows up on `xfer_addr` or `new_base` one cycle after the request that uses it. Which of the two outputs is wrong depends on the indexing mode, so the bench drives both modes with every shift kind and with both directions. A wrong indexing decision appears as a swapped address and base, or as a wrong `base_we`, in that same response cycle. A capture register that loads when it should hold is only visible during idle cycles. For that reason the bench inserts idle gaps and compares every output on every clock, not only on the valid cycles.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
    localparam int ADDR_W  = 32;
    localparam int IMM_W   = 12;
    localparam int SHAMT_W = $clog2(ADDR_W);

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_LRIGHT = 2'b01,
        SH_ARIGHT = 2'b10,
        SH_ROTR  = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nbase;
        logic              we;
    } agu_state_t;
endpackage

// File: rtl/agu_shifter.sv
`timescale 1ns/1ps
module agu_shifter
    import agu_pkg::*;
#(
    parameter int W   = ADDR_W,
    parameter int AMT = $clog2(W)
) (
    input  logic [W-1:0]   shift_in,
    input  shift_kind_e    kind,
    input  logic [AMT-1:0] amt,
    output logic [W-1:0]   shift_out
);
    // Logarithmic barrel: stage i moves the value by 2**i when amt[i] is set.
    logic [W-1:0] stage [AMT+1];

    assign stage[0] = shift_in;

    for (genvar i = 0; i < AMT; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            unique case (kind)
                SH_LEFT:   moved = {stage[i][W-S-1:0], {S{1'b0}}};
                SH_LRIGHT: moved = {{S{1'b0}}, stage[i][W-1:S]};
                SH_ARIGHT: moved = {{S{stage[i][W-1]}}, stage[i][W-1:S]};
                default:   moved = {stage[i][S-1:0], stage[i][W-1:S]};
            endcase
        end
        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign shift_out = stage[AMT];

    always_comb begin
        if (amt == '0) begin
            a_r2_zero_amount_passes: assert (shift_out == shift_in);
        end
        if (kind == SH_ROTR) begin
            a_r5_rotate_keeps_ones: assert ($countones(shift_out) == $countones(shift_in));
        end
        if (kind == SH_ARIGHT) begin
            a_r4_sign_kept: assert (shift_out[W-1] == shift_in[W-1]);
        end
    end
endmodule

// File: rtl/agu_offset_sel.sv
`timescale 1ns/1ps
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int W  = ADDR_W,
    parameter int IW = IMM_W
) (
    input  logic          off_is_imm,
    input  logic [IW-1:0] imm_off,
    input  logic [W-1:0]  shifted_reg,
    output logic [W-1:0]  offset
);
    localparam int PAD = W - IW;

    assign offset = off_is_imm ? {{PAD{1'b0}}, imm_off} : shifted_reg;

    always_comb begin
        if (off_is_imm) begin
            a_r1_imm_upper_zero: assert (offset[W-1:IW] == '0);
        end
    end
endmodule

// File: rtl/agu_addr_calc.sv
`timescale 1ns/1ps
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] offset,
    input  logic         up,
    input  logic         pre,
    input  logic         wb_req,
    output logic [W-1:0] addr,
    output logic [W-1:0] nbase,
    output logic         we
);
    logic [W-1:0] adjusted;

    // Modulo 2**W: carries and borrows out of the top bit are dropped.
    assign adjusted = up ? (base + offset) : (base - offset);
    assign addr     = pre ? adjusted : base;
    assign nbase    = adjusted;
    assign we       = pre ? wb_req : 1'b1;

    always_comb begin
        if (up) begin
            a_r6_add_inverts: assert (W'(adjusted - offset) == base);
        end else begin
            a_r6_sub_inverts: assert (W'(adjusted + offset) == base);
        end
    end
endmodule

// File: rtl/ldst_agu.sv
`timescale 1ns/1ps
module ldst_agu
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] base_in,
    input  logic        off_is_imm,
    input  logic [11:0] imm_off,
    input  logic [31:0] reg_off,
    input  logic [1:0]  sh_kind,
    input  logic [4:0]  sh_amt,
    input  logic        up,
    input  logic        pre,
    input  logic        wb_req,
    output logic        rsp_valid,
    output logic [31:0] xfer_addr,
    output logic [31:0] new_base,
    output logic        base_we
);
    logic [ADDR_W-1:0] shifted;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] calc_nbase;
    logic              calc_we;

    agu_state_t st_d, st_q;

    agu_shifter #(.W(ADDR_W), .AMT(SHAMT_W)) u_shift (
        .shift_in  (reg_off),
        .kind      (shift_kind_e'(sh_kind)),
        .amt       (sh_amt),
        .shift_out (shifted)
    );

    agu_offset_sel #(.W(ADDR_W), .IW(IMM_W)) u_osel (
        .off_is_imm  (off_is_imm),
        .imm_off     (imm_off),
        .shifted_reg (shifted),
        .offset      (offset)
    );

    agu_addr_calc #(.W(ADDR_W)) u_calc (
        .base   (base_in),
        .offset (offset),
        .up     (up),
        .pre    (pre),
        .wb_req (wb_req),
        .addr   (calc_addr),
        .nbase  (calc_nbase),
        .we     (calc_we)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.addr  = calc_addr;
            st_d.nbase = calc_nbase;
            st_d.we    = calc_we;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign xfer_addr = st_q.addr;
    assign new_base  = st_q.nbase;
    assign base_we   = st_q.we;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(xfer_addr) && $stable(new_base) && $stable(base_we)));
    a_r7_pre_we: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pre) |=> (base_we == $past(wb_req)));
    a_r7_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pre) |=> (xfer_addr == new_base));
    a_r8_post_we: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pre) |=> base_we);
    a_r8_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pre) |=> (xfer_addr == $past(base_in)));
endmodule

// File: tb/ldst_agu_bench.sv
`timescale 1ns/1ps
module ldst_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_in = '0;
    logic        off_is_imm = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic [1:0]  sh_kind = '0;
    logic [4:0]  sh_amt = '0;
    logic        up = 1'b0;
    logic        pre = 1'b0;
    logic        wb_req = 1'b0;
    logic        rsp_valid;
    logic [31:0] xfer_addr;
    logic [31:0] new_base;
    logic        base_we;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_tag = "R11";

    // reference state
    logic        e_valid = 1'b0;
    logic [31:0] e_addr = '0;
    logic [31:0] e_nbase = '0;
    logic        e_we = 1'b0;
    string       e_tag = "R11";

    always #2.5 clk = ~clk;

    ldst_agu u_ldst_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_in(base_in),
        .off_is_imm(off_is_imm), .imm_off(imm_off), .reg_off(reg_off),
        .sh_kind(sh_kind), .sh_amt(sh_amt), .up(up), .pre(pre), .wb_req(wb_req),
        .rsp_valid(rsp_valid), .xfer_addr(xfer_addr), .new_base(new_base),
        .base_we(base_we)
    );

    function automatic logic [31:0] ref_shift(logic [31:0] v, logic [1:0] k, int n);
        logic [31:0] r;
        case (k)
            2'd0: r = v << n;
            2'd1: r = v >> n;
            2'd2: r = $unsigned($signed(v) >>> n);
            default: begin
                r = v;
                for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
            end
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid <= 1'b0; e_addr <= '0; e_nbase <= '0; e_we <= 1'b0; e_tag <= "R11";
        end else begin
            logic [31:0] off, adj;
            e_valid <= req_valid;
            if (req_valid) begin
                off = off_is_imm ? {20'd0, imm_off} : ref_shift(reg_off, sh_kind, int'(sh_amt));
                adj = up ? base_in + off : base_in - off;
                e_addr  <= pre ? adj : base_in;
                e_nbase <= adj;
                e_we    <= pre ? wb_req : 1'b1;
                e_tag   <= cur_tag;
            end else begin
                e_tag <= "R10";
            end
        end
    end

    task automatic check1(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check1("R9", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        check1(e_tag, "xfer_addr", xfer_addr, e_addr);
        check1(e_tag, "new_base", new_base, e_nbase);
        check1(e_tag, "base_we", 32'(base_we), 32'(e_we));
    endtask

    task automatic req(string tag, logic [31:0] b, logic imm, logic [11:0] io,
                       logic [31:0] ro, logic [1:0] k, logic [4:0] a,
                       logic u, logic p, logic w);
        cur_tag = tag; req_valid = 1'b1; base_in = b; off_is_imm = imm; imm_off = io;
        reg_off = ro; sh_kind = k; sh_amt = a; up = u; pre = p; wb_req = w;
        @(negedge clk); compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            req_valid = 1'b0;
            base_in = $urandom; reg_off = $urandom; imm_off = 12'($urandom);
            pre = 1'($urandom); wb_req = 1'($urandom);
            @(negedge clk); compare_all();
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        compare_all();                       // R11 during reset
        rst_n = 1'b1;
        @(negedge clk); compare_all();       // R11 just after release
        // R1: immediate, register fields must not matter
        req("R1", 32'h0000_1000, 1, 12'hFFF, 32'hDEAD_BEEF, 2'd3, 5'd7, 1, 1, 1);
        req("R1", 32'h0000_1000, 1, 12'h004, 32'h1234_5678, 2'd0, 5'd31, 0, 1, 0);
        // R2..R5 shift kinds, including amount 0 and 31
        req("R2", 32'h100, 0, 0, 32'h0000_0003, 2'd0, 5'd2, 1, 1, 0);
        req("R2", 32'h100, 0, 0, 32'h8000_0001, 2'd0, 5'd0, 1, 1, 0);
        req("R3", 32'h0, 0, 0, 32'hF000_0000, 2'd1, 5'd4, 1, 1, 1);
        req("R4", 32'h0, 0, 0, 32'h8000_0000, 2'd2, 5'd31, 1, 1, 1);
        req("R4", 32'h0, 0, 0, 32'h4000_0000, 2'd2, 5'd4, 1, 1, 1);
        req("R5", 32'h0, 0, 0, 32'h0000_00F1, 2'd3, 5'd6, 1, 1, 1);
        req("R5", 32'h0, 0, 0, 32'h1234_5678, 2'd3, 5'd0, 1, 1, 1);
        // R6 wrap-around both ways
        req("R6", 32'hFFFF_FFF0, 1, 12'h020, 0, 0, 0, 1, 1, 0);
        req("R6", 32'h0000_0008, 1, 12'h018, 0, 0, 0, 0, 1, 0);
        // R7 / R8 writeback rules
        req("R7", 32'h2000, 1, 12'h018, 0, 0, 0, 1, 1, 0);
        req("R7", 32'h2000, 1, 12'h018, 0, 0, 0, 1, 1, 1);
        req("R8", 32'h2000, 0, 0, 32'h0000_0005, 2'd0, 5'd3, 1, 0, 0);
        req("R8", 32'h2000, 0, 0, 32'h0000_0040, 2'd2, 5'd4, 0, 0, 1);
        idle(3);                              // R9, R10
        for (int t = 0; t < 400; t++) begin
            logic imm; logic [1:0] k; string tg;
            imm = 1'($urandom); k = 2'($urandom);
            if (imm) tg = "R1";
            else case (k) 2'd0: tg = "R2"; 2'd1: tg = "R3"; 2'd2: tg = "R4"; default: tg = "R5"; endcase
            req(tg, $urandom, imm, 12'($urandom), $urandom, k, 5'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule